// File: doc/BRIEF.md
# SPI Host Port with Word Request Pacing

This block is a serial host port that moves 24-bit words over a four-wire SPI link and works as either the clock-driving master or the clock-following slave, selected by a static mode input. Data is shifted most significant bit first with mode 0 timing: the receiving side samples on the rising SCK edge and the sending side changes data after the falling edge. A parallel transmit word is offered with a valid/ready handshake, and every completed word is presented on a parallel output with a one-cycle valid pulse.

An extra active-low request line paces the traffic word by word. As a slave the block drives this line low when it holds a transmit word and is waiting for a frame, and lets it go high at the first SCK edge of that frame. As a master it reads the line and starts a word only after the far end pulls it low, then waits for a fresh high-to-low transition before the next word. Two request-enable bits switch the pacing on; with both clear, the line is not driven and a master starts as soon as transmit data is offered. A master that sees its select input pulled low records a sticky bus error, cleared by a write-one-to-clear input.

In master mode SCK is made by dividing the system clock; in slave mode the external SCK, select and data inputs are brought through two-stage synchronisers before edges are detected, so the external SCK must be several times slower than the system clock.

Top module: `spi_req_port`

## Requirements
- R1: In master mode the block drives the transmit word on mosi_o MSB first, changing it only after falling SCK edges; sck_o idles low and each SCK phase lasts clk_div system clocks, a clk_div of 0 acting as 1.
- R2: In master mode the block samples miso_i on each rising edge of sck_o and assembles the 24 samples, first sample in bit 23, into rx_data.
- R3: In slave mode with ss_n low, the block samples mosi_i on each rising edge of sck_i into a 24-bit word (first sample in bit 23) and sends its loaded transmit word on miso_o MSB first, advancing one bit after each falling edge of sck_i.
- R4: In slave mode while ss_n is high, miso_oe is 0, sck_i edges produce no received word, and a partly shifted frame is dropped so the next frame starts at bit 23.
- R5: In master mode a low level on ss_n sets bus_err; bus_err stays set until err_clr is 1 for a cycle, and a clear does not win over a select that is still low.
- R6: In slave mode hreq_o is 0 while a transmit word is loaded and no frame bit has been shifted, and returns to 1 once the first rising sck_i edge of the frame is seen; it is 1 when no word is loaded.
- R7: hreq_oe is 0 during reset, in master mode, and whenever both req_en bits are 0; it is 1 in slave mode out of reset with either req_en bit set.
- R8: In master mode with either req_en bit set, a word starts only after hreq_i is seen low, and after each word no further word starts until hreq_i has been seen high and then low again.
- R9: In master mode with both req_en bits 0, tx_ready is 1 whenever no word is in progress, so a word starts as soon as tx_valid is offered, whatever hreq_i does.
- R10: rx_valid is a single-cycle pulse issued once per completed word, with the word on rx_data in the same cycle.
- R11: After reset rx_valid, bus_err, sck_o and hreq_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 selects master mode, 0 slave mode; changed only while idle |
| req_en | input | 2 | Request pacing enables; any set bit turns pacing on |
| clk_div | input | 8 | SCK phase length in system clocks (master mode) |
| tx_data | input | 24 | Word to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Block takes tx_data on a clock edge where tx_valid is also 1 |
| rx_data | output | 24 | Last received word |
| rx_valid | output | 1 | One-cycle pulse, rx_data holds a new word |
| bus_err | output | 1 | Sticky flag: select seen low while master |
| err_clr | input | 1 | Write-one-to-clear for bus_err |
| sck_o | output | 1 | Generated serial clock (master mode) |
| sck_i | input | 1 | External serial clock (slave mode) |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Output enable for miso_o; 0 means high impedance |
| ss_n | input | 1 | Active-low slave select |
| hreq_i | input | 1 | Request line read in master mode, active low |
| hreq_o | output | 1 | Request line value driven in slave mode, active low |
| hreq_oe | output | 1 | Output enable for hreq_o; 0 means high impedance |

## Verification
The embedded assertions watch, on every cycle, that a deselected slave produces no received word, that the request line is released right after a detected rising SCK edge, that the bus-error flag sets and holds as required, that a paced master never starts while disarmed, that the generated clock idles low, and that the word strobe never lasts two cycles. The bit order and content of words in both directions, the SCK phase length for different divider settings, dropping of an aborted frame, the full high-then-low request cycle between master words, and the tri-state enables under reset and mode changes can only be shown by the bench's scenarios, which model the far end of the link and compare whole words against a queue of expected results.

// File: rtl/spi_req_port.sv
module spi_req_port #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic [1:0]        req_en,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              bus_err,
  input  logic              err_clr,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              mosi_o,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n,
  input  logic              hreq_i,
  output logic              hreq_o,
  output logic              hreq_oe
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [2:0]        sck_sy;
  logic [1:0]        ss_sy, mosi_sy, hreq_sy;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [DIV_W-1:0]  divcnt;
  logic              rxv_q, err_q, busy, sck_q, armed, loaded;

  wire s_rise   = sck_sy[1] & ~sck_sy[2];
  wire s_fall   = ~sck_sy[1] & sck_sy[2];
  wire ss_act   = ~ss_sy[1];
  wire hreq_low = ~hreq_sy[1];
  wire paced    = |req_en;
  wire last     = bitcnt == CNT_W'(WORD_W - 1);

  wire [DIV_W-1:0]  half    = (clk_div == '0) ? DIV_W'(1) : clk_div;
  wire              tick    = divcnt == half - 1'b1;
  wire              m_go    = !busy && (!paced || (armed && hreq_low));
  wire              take    = tx_valid && tx_ready;
  wire [WORD_W-1:0] rx_next = {rx_sh[WORD_W-2:0], cfg_master ? miso_i : mosi_sy[1]};

  assign tx_ready = cfg_master ? m_go : (!loaded && bitcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
      hreq_sy <= '1;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck_i};
      ss_sy   <= {ss_sy[0], ss_n};
      mosi_sy <= {mosi_sy[0], mosi_i};
      hreq_sy <= {hreq_sy[0], hreq_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      bitcnt <= '0;
      divcnt <= '0;
      rxv_q  <= 1'b0;
      err_q  <= 1'b0;
      busy   <= 1'b0;
      sck_q  <= 1'b0;
      armed  <= 1'b1;
      loaded <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      err_q <= (err_q & ~err_clr) | (cfg_master & ss_act);
      if (cfg_master) begin
        loaded <= 1'b0;
        if (!hreq_low) armed <= 1'b1;
        if (!busy) begin
          sck_q  <= 1'b0;
          divcnt <= '0;
          if (take) begin
            busy   <= 1'b1;
            tx_sh  <= tx_data;
            bitcnt <= '0;
            if (paced) armed <= 1'b0;
          end
        end else if (tick) begin
          divcnt <= '0;
          sck_q  <= ~sck_q;
          if (!sck_q) begin
            rx_sh <= rx_next;
          end else if (last) begin
            busy   <= 1'b0;
            rx_q   <= rx_sh;
            rxv_q  <= 1'b1;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            tx_sh  <= tx_sh << 1;
          end
        end else begin
          divcnt <= divcnt + 1'b1;
        end
      end else begin
        busy   <= 1'b0;
        sck_q  <= 1'b0;
        divcnt <= '0;
        if (take) begin
          loaded <= 1'b1;
          tx_sh  <= tx_data;
        end
        if (!ss_act) begin
          bitcnt <= '0;
        end else if (s_rise) begin
          rx_sh <= rx_next;
          if (last) begin
            rx_q   <= rx_next;
            rxv_q  <= 1'b1;
            bitcnt <= '0;
            loaded <= 1'b0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end else if (s_fall && bitcnt != '0) begin
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  assign rx_data  = rx_q;
  assign rx_valid = rxv_q;
  assign bus_err  = err_q;
  assign sck_o    = cfg_master & sck_q;
  assign mosi_o   = cfg_master & tx_sh[WORD_W-1];
  assign miso_o   = tx_sh[WORD_W-1];
  assign miso_oe  = ~cfg_master & ~ss_n;
  assign hreq_o   = ~(loaded && bitcnt == '0);
  assign hreq_oe  = rst_n & paced & ~cfg_master;

  // R4
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !ss_act) |=> !rx_valid);

  // R6
  hreq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && ss_act && s_rise) |=> hreq_o);

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && ss_act) |=> bus_err);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !err_clr) |=> bus_err);

  // R8
  paced_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && paced && !busy && !armed) |=> !busy);

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !busy) |-> !sck_o);

  // R10
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: tb/test_spi_req_port.sv
module test_spi_req_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b0;
  logic [1:0]  req_en = 2'b11;
  logic [7:0]  clk_div = 8'd2;
  logic [23:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [23:0] rx_data;
  logic        rx_valid, bus_err;
  logic        err_clr = 1'b0;
  logic        sck_o, sck_i = 1'b0;
  logic        mosi_o, mosi_i = 1'b0;
  logic        miso_i, miso_o, miso_oe;
  logic        ss_n = 1'b1;
  logic        hreq_i = 1'b1;
  logic        hreq_o, hreq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] q_rx[$];
  logic [23:0] q_mosi[$];

  always #4 clk = ~clk;

  spi_req_port i_spi_req_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .req_en(req_en),
    .clk_div(clk_div), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .bus_err(bus_err), .err_clr(err_clr),
    .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n(ss_n),
    .hreq_i(hreq_i), .hreq_o(hreq_o), .hreq_oe(hreq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] far_word(input int n);
    return 24'(n * 32'h0013_5B7) ^ 24'hC35A96;
  endfunction

  // far-end slave model used in master mode
  int          bi = 0;
  int          sn = 0;
  int          mcnt = 0;
  logic [23:0] far_cur = far_word(0);
  logic [23:0] cap_m = '0;
  logic        miso_b = far_word(0) >> 23;
  int          rise_cnt = 0;
  time         last_rise = 0;
  time         sck_per = 0;
  assign miso_i = miso_b;

  always @(posedge sck_o) begin
    rise_cnt++;
    sck_per = $time - last_rise;
    last_rise = $time;
    cap_m = {cap_m[22:0], mosi_o};
    bi++;
    if (bi == 24) begin
      if (q_mosi.size() == 0) chk("R1 unexpected master word", 32'(cap_m), 32'hFFFF_FFFF);
      else chk("R1 master mosi word", 32'(cap_m), 32'(q_mosi.pop_front()));
    end
  end

  always @(negedge sck_o) begin
    if (bi == 24) begin
      bi = 0;
      sn++;
      far_cur = far_word(sn);
      miso_b = far_cur[23];
    end else begin
      miso_b = far_cur[23 - bi];
    end
  end

  // monitor: compare received words against expected queue
  logic prev_rxv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && prev_rxv) chk("R10 rx_valid width", 32'd2, 32'd1);
      if (rx_valid) begin
        if (q_rx.size() == 0) chk("R10 unexpected rx word", 32'(rx_data), 32'hFFFF_FFFF);
        else chk("R2/R3 rx word", 32'(rx_data), 32'(q_rx.pop_front()));
      end
    end
    prev_rxv = rx_valid;
  end

  task automatic load_tx(input logic [23:0] w);
    @(negedge clk);
    tx_data = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_m(input logic [23:0] w);
    q_mosi.push_back(w);
    q_rx.push_back(far_word(mcnt));
    mcnt++;
    load_tx(w);
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 4000 && (q_rx.size() != 0 || q_mosi.size() != 0); i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = w[23 - i];
      repeat (8) @(negedge clk);
      got = {got[22:0], miso_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      if (i == 0) chk("R6 hreq released after first edge", 32'(hreq_o), 32'd1);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    int r0;

    repeat (3) @(negedge clk);
    chk("R7 hreq_oe in reset", 32'(hreq_oe), 32'd0);
    chk("R11 rx_valid reset", 32'(rx_valid), 32'd0);
    chk("R11 bus_err reset", 32'(bus_err), 32'd0);
    chk("R11 sck_o reset", 32'(sck_o), 32'd0);
    rst_n = 1'b1;
    req_en = 2'b10;
    repeat (3) @(negedge clk);
    chk("R7 hreq_oe slave paced", 32'(hreq_oe), 32'd1);
    chk("R6 hreq high without word", 32'(hreq_o), 32'd1);
    req_en = 2'b00;
    @(negedge clk);
    chk("R7 hreq_oe with enables clear", 32'(hreq_oe), 32'd0);
    req_en = 2'b10;

    // R4: deselected slave ignores SCK, MISO released
    for (int i = 0; i < 10; i++) begin
      sck_i = ~sck_i;
      repeat (4) @(negedge clk);
      if (i == 5) chk("R4 miso_oe deselected", 32'(miso_oe), 32'd0);
    end
    sck_i = 1'b0;
    repeat (4) @(negedge clk);
    // R4: aborted partial frame
    xfer(24'hFFFFFF, 5, got);

    load_tx(24'h9C31E7);
    chk("R6 hreq low with word loaded", 32'(hreq_o), 32'd0);
    q_rx.push_back(24'h3A5C81);
    ss_n = 1'b0;
    @(negedge clk);
    chk("R4 miso_oe selected", 32'(miso_oe), 32'd1);
    xfer(24'h3A5C81, 24, got);
    chk("R3 slave miso word", 32'(got), 32'h9C31E7);

    load_tx(24'h00F0FF);
    q_rx.push_back(24'hE00007);
    xfer(24'hE00007, 24, got);
    chk("R3 slave miso word 2", 32'(got), 32'h00F0FF);
    wait_empty();
    chk("R4 aborted frame dropped", 32'(q_rx.size()), 32'd0);

    // master, unpaced
    cfg_master = 1'b1;
    req_en = 2'b00;
    clk_div = 8'd2;
    repeat (4) @(negedge clk);
    chk("R7 hreq_oe in master", 32'(hreq_oe), 32'd0);
    chk("R9 tx_ready unpaced idle", 32'(tx_ready), 32'd1);
    send_m(24'hA1B2C3);
    send_m(24'h800001);
    wait_empty();
    chk("R1 sck period div2", 32'(sck_per), 32'd32);
    clk_div = 8'd0;
    send_m(24'h5F0A33);
    wait_empty();
    chk("R1 sck period div0", 32'(sck_per), 32'd16);
    chk("R1 sck idle low", 32'(sck_o), 32'd0);

    // master, paced by hreq
    clk_div = 8'd2;
    req_en = 2'b01;
    hreq_i = 1'b1;
    r0 = rise_cnt;
    fork send_m(24'h123456); join_none
    repeat (40) @(negedge clk);
    chk("R8 no start before hreq low", 32'(rise_cnt - r0), 32'd0);
    hreq_i = 1'b0;
    wait_empty();
    r0 = rise_cnt;
    fork send_m(24'hFEDCBA); join_none
    repeat (100) @(negedge clk);
    chk("R8 no restart without new request", 32'(rise_cnt - r0), 32'd0);
    hreq_i = 1'b1;
    repeat (4) @(negedge clk);
    hreq_i = 1'b0;
    wait_empty();
    chk("R8 second paced word done", 32'(rise_cnt - r0), 32'd24);
    hreq_i = 1'b1;

    // bus error
    chk("R5 bus_err clear before", 32'(bus_err), 32'd0);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 bus_err set", 32'(bus_err), 32'd1);
    repeat (5) @(negedge clk);
    chk("R5 bus_err sticky", 32'(bus_err), 32'd1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
    chk("R5 bus_err cleared", 32'(bus_err), 32'd0);

    chk("R10 all words seen", 32'(q_rx.size() + q_mosi.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule